// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss for a device-side address translation unit. It accepts a 32-bit device virtual address and the base of a first-level table, then reads descriptors from memory through a simple read port that allows only one read in flight. The first read fetches the first-level descriptor. That descriptor is either a leaf mapping, a pointer to a second-level table, or no mapping. A pointer triggers a second read for the second-level descriptor.

A successful walk ends with a one-cycle done pulse that carries the physical address, a two-bit page-size code and the attribute bits of the leaf descriptor. A walk that finds no mapping ends with a one-cycle fault pulse that carries the virtual address. The table format supports four page sizes: 4 KB, 64 KB, 1 MB and 16 MB. The 16 MB and 64 KB mappings are stored as sixteen identical copies. The walker therefore reads whichever copy the address selects, takes the page size from the descriptor type, and masks the address to that size.

Top module: `ptw_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `done_o`, `fault_o` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to address `{req_base[31:14], req_va[31:20], 2'b00}`.
- R3: A first-level descriptor with bits [1:0] = 2'b10 and bit 18 = 0 is a 1 MB leaf. It gives `done_pa = {desc[31:20], va[19:0]}` and size code 2'b00, and no second read is made.
- R4: A first-level descriptor with bits [1:0] = 2'b10 and bit 18 = 1 is a 16 MB leaf. It gives `done_pa = {desc[31:24], va[23:0]}` and size code 2'b11, for any of its sixteen copies.
- R5: A first-level descriptor with bits [1:0] = 2'b01 points to a second-level table. The second read goes to `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor with bit 1 = 1 is a 4 KB leaf. It gives `done_pa = {desc[31:12], va[11:0]}` and size code 2'b10.
- R7: A second-level descriptor with bits [1:0] = 2'b01 is a 64 KB leaf. It gives `done_pa = {desc[31:16], va[15:0]}` and size code 2'b01, for any of its sixteen copies.
- R8: `done_attr` equals bits [11:2] of the leaf descriptor that ended the walk.
- R9: A first-level descriptor with bits [1:0] of 2'b00 (including all-zero) or 2'b11, or a second-level descriptor with bits [1:0] = 2'b00, ends the walk with `fault_o` and `fault_va` equal to the walked virtual address. No further read is made.
- R10: Each accepted walk produces exactly one single-cycle pulse, either on `done_o` or on `fault_o`, and never both.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays high with a stable address. At most one read is in flight.
- R12: A request is taken only while `req_ready` is high, and `req_ready` is low during a walk and during its result cycle. A request held high through a walk is served after that walk.
- R13: A `mem_rsp_valid` pulse that arrives while no read is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Device virtual address to translate |
| req_base | input | 32 | First-level table base (16 KB aligned) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| done_o | output | 1 | One-cycle pulse for a successful walk |
| done_pa | output | 32 | Translated physical address |
| done_size | output | 2 | Page size: 00 1 MB, 01 64 KB, 10 4 KB, 11 16 MB |
| done_attr | output | ATTR_W | Leaf attribute bits |
| fault_o | output | 1 | One-cycle pulse for a walk with no mapping |
| fault_va | output | 32 | Virtual address of the faulting walk |

## Verification
Two events can coincide. In the first, a response strobe arrives while the walker is still waiting for its own read to be granted. The bench stalls the grant for several cycles, injects a bogus response during the stall, and then requires the real descriptor to produce the correct result with only one read counted. In the second, a new request arrives in the same cycle as a result pulse. The bench holds `req_valid` high with a second address through the first walk. It requires `req_ready` to be low in the done cycle, the first result to be unaffected, and the second walk to start only afterwards and finish correctly.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W       = 32;
  localparam int unsigned L1_BASE_LSB = 14;
  localparam int unsigned L1_IDX_LSB  = 20;
  localparam int unsigned L2_BASE_LSB = 10;
  localparam int unsigned L2_IDX_LSB  = 12;
  localparam int unsigned SUPER_BIT   = 18;
  localparam int unsigned ATTR_LSB    = 2;

  typedef enum logic [1:0] {
    SZ_1M  = 2'b00,
    SZ_64K = 2'b01,
    SZ_4K  = 2'b10,
    SZ_16M = 2'b11
  } pgsz_e;

  typedef enum logic [1:0] {
    L1K_FAULT = 2'd0,
    L1K_TABLE = 2'd1,
    L1K_LEAF  = 2'd2
  } l1_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_st_e;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
#(
  parameter int unsigned ATTR_W = 10
) (
  input  logic [VA_W-1:0]   desc,
  input  logic [VA_W-1:0]   va,
  output l1_kind_e          kind,
  output logic [VA_W-1:0]   leaf_pa,
  output pgsz_e             leaf_size,
  output logic [VA_W-1:0]   next_addr,
  output logic [ATTR_W-1:0] attr
);
  localparam int unsigned SUPER_LSB = L1_IDX_LSB + 4;

  logic unused_bits;
  assign unused_bits = ^{desc, va};

  always_comb begin
    unique case (desc[1:0])
      2'b01:   kind = L1K_TABLE;
      2'b10:   kind = L1K_LEAF;
      default: kind = L1K_FAULT;
    endcase
  end

  always_comb begin
    if (desc[SUPER_BIT]) begin
      leaf_pa   = {desc[VA_W-1:SUPER_LSB], va[SUPER_LSB-1:0]};
      leaf_size = SZ_16M;
    end else begin
      leaf_pa   = {desc[VA_W-1:L1_IDX_LSB], va[L1_IDX_LSB-1:0]};
      leaf_size = SZ_1M;
    end
  end

  assign next_addr = {desc[VA_W-1:L2_BASE_LSB], va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
  assign attr      = desc[ATTR_LSB +: ATTR_W];
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
#(
  parameter int unsigned ATTR_W = 10
) (
  input  logic [VA_W-1:0]   desc,
  input  logic [VA_W-1:0]   va,
  output logic              hit,
  output logic [VA_W-1:0]   leaf_pa,
  output pgsz_e             leaf_size,
  output logic [ATTR_W-1:0] attr
);
  localparam int unsigned LARGE_LSB = L2_IDX_LSB + 4;

  logic unused_bits;
  assign unused_bits = ^{desc, va};

  assign hit = (desc[1:0] != 2'b00);

  always_comb begin
    if (desc[1]) begin
      leaf_pa   = {desc[VA_W-1:L2_IDX_LSB], va[L2_IDX_LSB-1:0]};
      leaf_size = SZ_4K;
    end else begin
      leaf_pa   = {desc[VA_W-1:LARGE_LSB], va[LARGE_LSB-1:0]};
      leaf_size = SZ_64K;
    end
  end

  assign attr = desc[ATTR_LSB +: ATTR_W];
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned ATTR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic [31:0]       req_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done_o,
  output logic [31:0]       done_pa,
  output logic [1:0]        done_size,
  output logic [ATTR_W-1:0] done_attr,
  output logic              fault_o,
  output logic [31:0]       fault_va
);
  walk_st_e          state_q;
  logic [VA_W-1:0]   va_q;
  logic [VA_W-1:0]   addr_q;
  logic [VA_W-1:0]   pa_q;
  pgsz_e             size_q;
  logic [ATTR_W-1:0] attr_q;

  l1_kind_e          l1_kind;
  logic [VA_W-1:0]   l1_pa;
  pgsz_e             l1_size;
  logic [VA_W-1:0]   l1_next;
  logic [ATTR_W-1:0] l1_attr;

  logic              l2_hit;
  logic [VA_W-1:0]   l2_pa;
  pgsz_e             l2_size;
  logic [ATTR_W-1:0] l2_attr;

  ptw_l1_decode #(.ATTR_W(ATTR_W)) u_l1 (
    .desc      (mem_rsp_data),
    .va        (va_q),
    .kind      (l1_kind),
    .leaf_pa   (l1_pa),
    .leaf_size (l1_size),
    .next_addr (l1_next),
    .attr      (l1_attr)
  );

  ptw_l2_decode #(.ATTR_W(ATTR_W)) u_l2 (
    .desc      (mem_rsp_data),
    .va        (va_q),
    .hit       (l2_hit),
    .leaf_pa   (l2_pa),
    .leaf_size (l2_size),
    .attr      (l2_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      size_q  <= SZ_1M;
      attr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            addr_q  <= {req_base[VA_W-1:L1_BASE_LSB], req_va[VA_W-1:L1_IDX_LSB], 2'b00};
            state_q <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (l1_kind)
              L1K_TABLE: begin
                addr_q  <= l1_next;
                state_q <= ST_L2_REQ;
              end
              L1K_LEAF: begin
                pa_q    <= l1_pa;
                size_q  <= l1_size;
                attr_q  <= l1_attr;
                state_q <= ST_DONE;
              end
              default: state_q <= ST_FAULT;
            endcase
          end
        end
        ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            if (l2_hit) begin
              pa_q    <= l2_pa;
              size_q  <= l2_size;
              attr_q  <= l2_attr;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_FAULT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr  = addr_q;
  assign done_o        = (state_q == ST_DONE);
  assign done_pa       = pa_q;
  assign done_size     = size_q;
  assign done_attr     = attr_q;
  assign fault_o       = (state_q == ST_FAULT);
  assign fault_va      = va_q;

  // R11: a request not yet granted stays up with the same address
  a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: the first read follows the accepted request with the table-indexed address
  a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req_valid &&
      mem_req_addr == {$past(req_base[31:14]), $past(req_va[31:20]), 2'b00}));

  // R10: result pulses are exclusive and last one cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !fault_o);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> !fault_o);

  // R12: no request is taken in a result cycle
  a_r12_busy_result: assert property (@(posedge clk) disable iff (rst)
    (done_o || fault_o) |-> !req_ready);
endmodule

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h8000_4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = BASE;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_o;
  logic [31:0] done_pa;
  logic [1:0]  done_size;
  logic [9:0]  done_attr;
  logic        fault_o;
  logic [31:0] fault_va;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [logic [31:0]];
  int          gnt_hold = 0;
  int          rsp_lat = 0;
  bit          stray_arm = 0;
  bit          stray_idle = 0;
  bit          pend = 0;
  int          wait_cnt = 0;
  logic [31:0] pend_addr = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [0:3];

  logic        w_done, w_fault;
  logic [31:0] w_pa, w_fva;
  logic [1:0]  w_size;
  logic [9:0]  w_attr;

  ptw_top u_ptw_top (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_o(done_o), .done_pa(done_pa), .done_size(done_size), .done_attr(done_attr),
    .fault_o(fault_o), .fault_va(fault_va)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return {BASE[31:14], va[31:20], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model: one read at a time, response rsp_lat cycles after grant
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (mem_req_valid && gnt_hold > 0) begin
        gnt_hold--;
        mem_req_ready = 1'b0;
        if (stray_arm) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = 32'hFFFF_FFFE;
          stray_arm     = 0;
        end
      end else begin
        mem_req_ready = 1'b1;
      end
      if (stray_idle) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h0000_0002;
        stray_idle    = 0;
      end
      if (pend) begin
        if (wait_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mrd(pend_addr);
          pend = 0;
        end else begin
          wait_cnt--;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
        rd_cnt++;
        pend      = 1;
        pend_addr = mem_req_addr;
        wait_cnt  = rsp_lat;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    summary();
  end

  task automatic wait_result();
    for (int i = 0; i < 60; i++) begin
      if (done_o || fault_o) break;
      @(negedge clk);
    end
    w_done  = done_o;
    w_fault = fault_o;
    w_pa    = done_pa;
    w_size  = done_size;
    w_attr  = done_attr;
    w_fva   = fault_va;
  endtask

  task automatic walk(input logic [31:0] va);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result();
    @(negedge clk);
    chk("R10 pulse ends", {30'h0, done_o, fault_o}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 done_o", {31'h0, done_o}, 32'h0);
    chk("R1 fault_o", {31'h0, fault_o}, 32'h0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h1234_5678;
    logic [31:0] d  = 32'hABC0_0A86;
    mem[l1a(va)] = d;
    rsp_lat = 0;
    walk(va);
    chk("R10 section done", {30'h0, w_done, w_fault}, 32'h2);
    chk("R2 first read addr", rd_addr[0], l1a(va));
    chk("R3 section pa", w_pa, {d[31:20], va[19:0]});
    chk("R3 section size", {30'h0, w_size}, 32'h0);
    chk("R3 single read", rd_cnt, 1);
    chk("R8 section attr", {22'h0, w_attr}, {22'h0, d[11:2]});
  endtask

  task automatic t_super();
    logic [31:0] va = 32'h5A7B_CDEF;
    logic [31:0] d  = 32'h7704_031E;
    for (int k = 0; k < 16; k++) mem[l1a({va[31:24], 24'h0}) + 32'(k * 4)] = d;
    rsp_lat = 2;
    walk(va);
    chk("R4 super done", {30'h0, w_done, w_fault}, 32'h2);
    chk("R4 super pa", w_pa, {d[31:24], va[23:0]});
    chk("R4 super size", {30'h0, w_size}, 32'h3);
    chk("R8 super attr", {22'h0, w_attr}, {22'h0, d[11:2]});
  endtask

  task automatic t_small();
    logic [31:0] va = 32'h0030_1ABC;
    logic [31:0] t  = 32'h0010_0C01;
    logic [31:0] d  = 32'h4567_8FFE;
    logic [31:0] a2 = {t[31:10], va[19:12], 2'b00};
    mem[l1a(va)] = t;
    mem[a2] = d;
    rsp_lat = 1;
    walk(va);
    chk("R5 second read addr", rd_addr[1], a2);
    chk("R5 two reads", rd_cnt, 2);
    chk("R6 small pa", w_pa, {d[31:12], va[11:0]});
    chk("R6 small size", {30'h0, w_size}, 32'h2);
    chk("R8 small attr", {22'h0, w_attr}, {22'h0, d[11:2]});
  endtask

  task automatic t_large();
    logic [31:0] va = 32'h0047_3456;
    logic [31:0] t  = 32'h0020_0001;
    logic [31:0] d  = 32'h9ABC_0555;
    mem[l1a(va)] = t;
    for (int k = 0; k < 16; k++) mem[{t[31:10], va[19:16], 4'(k), 2'b00}] = d;
    rsp_lat = 0;
    walk(va);
    chk("R7 large done", {30'h0, w_done, w_fault}, 32'h2);
    chk("R7 large pa", w_pa, {d[31:16], va[15:0]});
    chk("R7 large size", {30'h0, w_size}, 32'h1);
    chk("R8 large attr", {22'h0, w_attr}, {22'h0, d[11:2]});
  endtask

  task automatic t_faults();
    logic [31:0] va0 = 32'hFFF0_0010;
    logic [31:0] va1 = 32'h0060_0000;
    logic [31:0] va2 = 32'h0030_2000;
    walk(va0);
    chk("R9 empty L1 fault", {30'h0, w_done, w_fault}, 32'h1);
    chk("R9 empty L1 fault_va", w_fva, va0);
    chk("R9 empty L1 one read", rd_cnt, 1);
    mem[l1a(va1)] = 32'h1234_5673;
    walk(va1);
    chk("R9 reserved L1 fault", {30'h0, w_done, w_fault}, 32'h1);
    chk("R9 reserved L1 fault_va", w_fva, va1);
    chk("R9 reserved L1 one read", rd_cnt, 1);
    walk(va2);
    chk("R9 empty L2 fault", {30'h0, w_done, w_fault}, 32'h1);
    chk("R9 empty L2 fault_va", w_fva, va2);
    chk("R9 empty L2 two reads", rd_cnt, 2);
  endtask

  task automatic t_stall();
    logic [31:0] va = 32'h1234_0001;
    logic [31:0] d  = mrd(l1a(va));
    gnt_hold  = 3;
    stray_arm = 1;
    rsp_lat   = 2;
    walk(va);
    chk("R11 stalled grant result", w_pa, {d[31:20], va[19:0]});
    chk("R11 one read under stall", rd_cnt, 1);
    chk("R11 stalled read addr", rd_addr[0], l1a(va));
    chk("R13 bogus strobe during stall", {30'h0, w_done, w_fault}, 32'h2);
  endtask

  task automatic t_held();
    logic [31:0] va_a = 32'h1230_0004;
    logic [31:0] va_b = 32'h0030_1008;
    logic [31:0] da   = mrd(l1a(va_a));
    logic [31:0] db   = mrd({mrd(l1a(va_b)) & 32'hFFFF_FC00} | {22'h0, va_b[19:12], 2'b00});
    rsp_lat = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va_a;
    @(negedge clk);
    req_va = va_b;
    wait_result();
    chk("R12 not ready in done cycle", {31'h0, req_ready}, 32'h0);
    chk("R12 first result kept", w_pa, {da[31:20], va_a[19:0]});
    @(negedge clk);
    chk("R12 ready after result", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_result();
    chk("R12 held request served", w_pa, {db[31:12], va_b[11:0]});
    @(negedge clk);
  endtask

  task automatic t_stray_idle();
    logic [31:0] va = 32'h1234_5678;
    logic [31:0] d  = mrd(l1a(va));
    stray_idle = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R13 idle strobe no result", {30'h0, done_o, fault_o}, 32'h0);
    end
    chk("R13 still idle", {31'h0, req_ready}, 32'h1);
    walk(va);
    chk("R13 next walk clean", w_pa, {d[31:20], va[19:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_section();
    t_super();
    t_small();
    t_large();
    t_faults();
    t_stall();
    t_held();
    t_stray_idle();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule